// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh and Self-Refresh Scheduler

This block keeps a page-mode DRAM's contents alive by issuing distributed CAS-before-RAS (CBR) refresh cycles at a fixed per-row interval. The DRAM supplies the row address from its own internal counter during CBR, so the scheduler never drives an address. It only sequences the two strobes. Each pass through the interval counter adds one refresh to a pending count. The scheduler then asks the access sequencer for the DRAM bus and runs the owed refreshes back to back once the bus is granted.

On command, the scheduler can also put the DRAM into its low-power self-refresh state. It starts a CBR cycle and keeps RAS# low for the minimum entry time, then acknowledges. When the command is withdrawn, it raises the strobes and keeps RAS# high for the exit recovery time before it drops the acknowledge. While the DRAM refreshes itself, the scheduler's own interval is frozen and its pending count is discarded. Because refresh was distributed before entry, no burst refresh is issued after wake.

The strobes are valid only while the grant is held. The access sequencer is expected to multiplex them onto the pins during that time.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `ras_n` and `cas_n` are high, and `bus_req` and `sleep_ack` are low.
- R2: A refresh becomes owed every `REF_INTERVAL` clocks, counted from reset release or from the end of a wake. With the bus always granted, exactly one CBR refresh is issued per interval.
- R3: Owed refreshes accumulate while the grant is withheld, saturating at `PEND_MAX`. After the grant arrives, all of them are issued back to back.
- R4: `bus_req` is high whenever a refresh is owed or sleep is requested. It drops only when the owed count is zero and the last precharge has finished.
- R5: `ras_n` and `cas_n` remain high in every cycle where `bus_gnt` is low.
- R6: Each refresh works as follows:
  - `cas_n` goes low `T_CSR` cycles before `ras_n` falls.
  - `ras_n` stays low for `T_RAS` cycles.
  - Both strobes rise in the same cycle.
  - At least `T_RP` high cycles on `ras_n` separate consecutive RAS# falls.
- R7: On a granted sleep request, a CBR cycle starts and RAS# is held low. `sleep_ack` rises exactly `T_RASS` cycles after `ras_n` falls, and `ras_n` then stays low while `sleep_req` is held.
- R8: After `sleep_req` drops, both strobes rise on the next clock. `sleep_ack` falls exactly `T_RPS` cycles later.
- R9: During self-refresh, no refresh cycle is issued. After wake, no refresh is requested until a full `REF_INTERVAL` has elapsed; the pending count is discarded.
- R10: A sleep request takes priority over owed refreshes. With refreshes owed and sleep requested when the grant arrives, the sleep-entry CBR is the only RAS# fall before `sleep_ack` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all timing parameters count its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Level request to enter and stay in self-refresh |
| sleep_ack | output | 1 | High from completed self-refresh entry until the exit recovery has elapsed |
| bus_req | output | 1 | Request for ownership of the DRAM strobes |
| bus_gnt | input | 1 | Ownership granted; held by the arbiter while `bus_req` is high |
| ras_n | output | 1 | Row strobe to drive while granted, active low |
| cas_n | output | 1 | Column strobe to drive while granted, active low |

## Verification
The bench holds the grant back across several intervals and then releases it. This exposes a scheduler that keeps only one pending flag, because it would issue one refresh instead of three. It also exposes a counter that wraps past its ceiling, because it would issue the wrong number after six missed intervals. A strobe monitor measures every CAS-to-RAS lead, RAS# width and precharge gap, which catches reversed strobe order or off-by-one state timers. Sleep is requested while refreshes are owed, so a scheduler without sleep priority would show extra RAS# falls before the acknowledge. The acknowledge edges are timed against the measured RAS# low and high periods. After wake, the bench watches for an early or burst refresh, which is what a design that kept counting or kept its backlog through self-refresh would produce.

// File: rtl/dram_refresh_pkg.sv
// Shared types and helpers for the DRAM refresh scheduler.
package dram_refresh_pkg;

    // Sequencer states: normal CBR refresh path, then the self-refresh path.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_CSETUP,
        ST_RACT,
        ST_PRECH,
        ST_SR_SETUP,
        ST_SR_HOLD,
        ST_SR_SLEEP,
        ST_SR_EXIT
    } ref_state_t;

    // Larger of two integers, used to size timers.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refresh_interval.sv
// Refresh interval counter and owed-refresh accumulator.
// Produces one tick every REF_INTERVAL clocks while not held; each tick adds
// one to a saturating pending count, each issued refresh removes one.
// Assumes: REF_INTERVAL >= 2, PEND_MAX >= 1. A clear overrides tick and issue.
module refresh_interval #(
    parameter  int REF_INTERVAL = 7812,
    parameter  int PEND_MAX     = 8,
    localparam int CW           = $clog2(REF_INTERVAL),
    localparam int PW           = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          issue,
    input  logic          clr,
    output logic [PW-1:0] pend_cnt,
    output logic          pend_any
);

    localparam logic [CW-1:0] LAST_CNT = CW'(REF_INTERVAL - 1);
    localparam logic [PW-1:0] PEND_TOP = PW'(PEND_MAX);

    logic [CW-1:0] int_cnt;
    logic          tick;

    // Interval counter: free-running, parked at zero while held.
    always_ff @(posedge clk) begin
        if (!rst_n)               int_cnt <= '0;
        else if (hold)            int_cnt <= '0;
        else if (int_cnt == LAST_CNT) int_cnt <= '0;
        else                      int_cnt <= int_cnt + 1'b1;
    end

    // Tick fires on the last count of each interval.
    assign tick = !hold && (int_cnt == LAST_CNT);

    // Pending count: up on tick, down on issue, saturating both ways.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_cnt <= '0;
        else if (clr)    pend_cnt <= '0;
        else begin
            case ({tick, issue})
                2'b10:   if (pend_cnt != PEND_TOP) pend_cnt <= pend_cnt + 1'b1;
                2'b01:   if (pend_cnt != '0)       pend_cnt <= pend_cnt - 1'b1;
                default: pend_cnt <= pend_cnt;
            endcase
        end
    end

    assign pend_any = (pend_cnt != '0);

    // R3
    pend_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= PEND_TOP);

    // R3
    tick_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !issue && !clr && pend_cnt != PEND_TOP) |=> pend_any);

endmodule

// File: rtl/refresh_timer.sv
// Down-counting phase timer shared by all sequencer states.
// A load sets the count; the count then falls by one per clock to zero and
// stays there. zero reports that the current phase has run its length.
module refresh_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Load or count down, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R6
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt < $past(cnt)));

endmodule

// File: rtl/refresh_seq.sv
// Strobe sequencer for CBR refresh and self-refresh entry/exit.
// Owns the bus request, the timing of CAS#/RAS# and the sleep acknowledge.
// Each phase lasts exactly its parameter in clocks (timer loaded with N-1).
// Assumes: the arbiter keeps bus_gnt high while bus_req is high once granted;
// all timing parameters are at least 1.
module refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int T_CSR  = 3,
    parameter int T_RAS  = 15,
    parameter int T_RP   = 10,
    parameter int T_RASS = 25000,
    parameter int T_RPS  = 33,
    parameter int TW     = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_req,
    input  logic          bus_gnt,
    input  logic          pend_any,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          issue,
    output logic          pend_clr,
    output logic          hold_int,
    output logic          bus_req,
    output logic          ras_n,
    output logic          cas_n,
    output logic          sleep_ack
);

    ref_state_t st, nxt;
    logic       work;

    assign work = pend_any || sleep_req;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next-state, timer loads and refresh issue pulse.
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        issue    = 1'b0;
        case (st)
            ST_IDLE: begin
                if (work) nxt = ST_REQ;
            end
            ST_REQ, ST_PRECH: begin
                if (st == ST_REQ || tmr_zero) begin
                    if (bus_gnt && sleep_req) begin
                        nxt      = ST_SR_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(T_CSR - 1);
                    end else if (bus_gnt && pend_any) begin
                        nxt      = ST_CSETUP;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(T_CSR - 1);
                        issue    = 1'b1;
                    end else if (work) begin
                        nxt = ST_REQ;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_CSETUP: begin
                if (tmr_zero) begin
                    nxt      = ST_RACT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_RAS - 1);
                end
            end
            ST_RACT: begin
                if (tmr_zero) begin
                    nxt      = ST_PRECH;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_RP - 1);
                end
            end
            ST_SR_SETUP: begin
                if (tmr_zero) begin
                    nxt      = ST_SR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_RASS - 1);
                end
            end
            ST_SR_HOLD: begin
                if (tmr_zero) nxt = ST_SR_SLEEP;
            end
            ST_SR_SLEEP: begin
                if (!sleep_req) begin
                    nxt      = ST_SR_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_RPS - 1);
                end
            end
            ST_SR_EXIT: begin
                if (tmr_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Strobes and handshakes decoded from the state register.
    assign cas_n     = !(st inside {ST_CSETUP, ST_RACT, ST_SR_SETUP, ST_SR_HOLD, ST_SR_SLEEP});
    assign ras_n     = !(st inside {ST_RACT, ST_SR_HOLD, ST_SR_SLEEP});
    assign bus_req   = (st != ST_IDLE);
    assign sleep_ack = (st inside {ST_SR_SLEEP, ST_SR_EXIT});
    assign pend_clr  = (st == ST_SR_SETUP);
    assign hold_int  = (st inside {ST_SR_SETUP, ST_SR_HOLD, ST_SR_SLEEP, ST_SR_EXIT});

    // Checker state: length of the current RAS# low and high runs.
    logic [31:0] ras_lo_cnt, ras_hi_cnt;

    // Run-length counters for the acknowledge timing checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_cnt <= '0;
            ras_hi_cnt <= '0;
        end else begin
            ras_lo_cnt <= ras_n ? '0 : ((ras_lo_cnt != '1) ? ras_lo_cnt + 1 : ras_lo_cnt);
            ras_hi_cnt <= !ras_n ? '0 : ((ras_hi_cnt != '1) ? ras_hi_cnt + 1 : ras_hi_cnt);
        end
    end

    // R6
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

    // R7
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_ack) |-> (!ras_n && ras_lo_cnt >= 32'(T_RASS)));

    // R8
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_ack) |-> (ras_n && ras_hi_cnt >= 32'(T_RPS)));

endmodule

// File: rtl/dram_refresh_sched.sv
// Top of the DRAM refresh scheduler: distributed CBR refresh plus
// self-refresh entry/exit. Wires the interval accumulator, phase timer and
// strobe sequencer. Strobes are meaningful only while bus_gnt is high.
// Assumes: clock-count parameters already converted from device times.
module dram_refresh_sched
    import dram_refresh_pkg::*;
#(
    parameter int REF_INTERVAL = 7812,
    parameter int PEND_MAX     = 8,
    parameter int T_CSR        = 3,
    parameter int T_RAS        = 15,
    parameter int T_RP         = 10,
    parameter int T_RASS       = 25000,
    parameter int T_RPS        = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic sleep_ack,
    output logic bus_req,
    input  logic bus_gnt,
    output logic ras_n,
    output logic cas_n
);

    localparam int TMAX = max2(max2(max2(T_CSR, T_RAS), max2(T_RP, T_RASS)), T_RPS);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(PEND_MAX + 1);

    logic          hold_int, issue, pend_clr, pend_any;
    logic [PW-1:0] pend_cnt;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;

    refresh_interval #(
        .REF_INTERVAL (REF_INTERVAL),
        .PEND_MAX     (PEND_MAX)
    ) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold_int),
        .issue    (issue),
        .clr      (pend_clr),
        .pend_cnt (pend_cnt),
        .pend_any (pend_any)
    );

    refresh_timer #(
        .W (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    refresh_seq #(
        .T_CSR  (T_CSR),
        .T_RAS  (T_RAS),
        .T_RP   (T_RP),
        .T_RASS (T_RASS),
        .T_RPS  (T_RPS),
        .TW     (TW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .bus_gnt   (bus_gnt),
        .pend_any  (pend_any),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .issue     (issue),
        .pend_clr  (pend_clr),
        .hold_int  (hold_int),
        .bus_req   (bus_req),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .sleep_ack (sleep_ack)
    );

    // R5
    gnt_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> bus_gnt);

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> ($past(pend_cnt) == '0));

    // R4
    pend_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt != '0) |=> bus_req);

endmodule

// File: tb/dram_refresh_sched_tb.sv
// Directed bench for the refresh scheduler; one task per scenario.
module dram_refresh_sched_tb;

    localparam int INT    = 100;
    localparam int PMAX   = 4;
    localparam int T_CSR  = 2;
    localparam int T_RAS  = 4;
    localparam int T_RP   = 3;
    localparam int T_RASS = 20;
    localparam int T_RPS  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic gate = 1'b0;
    logic sleep_ack, bus_req, bus_gnt, ras_n, cas_n;

    int tests = 0;
    int errors = 0;
    int cyc = 0;
    int falls = 0;
    bit sleep_mode = 1'b0;
    bit r5_viol = 1'b0;
    bit done = 1'b0;

    // Arbiter model: grants whenever requested and the gate is open.
    assign bus_gnt = gate & bus_req;

    dram_refresh_sched #(
        .REF_INTERVAL (INT),
        .PEND_MAX     (PMAX),
        .T_CSR        (T_CSR),
        .T_RAS        (T_RAS),
        .T_RP         (T_RP),
        .T_RASS       (T_RASS),
        .T_RPS        (T_RPS)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .sleep_ack (sleep_ack),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .ras_n     (ras_n),
        .cas_n     (cas_n)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Cycles since reset release.
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check_eq(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Strobe monitor: measures lead, width and gap of every RAS# pulse.
    int  cas_pre = 0, lo_run = 0, hi_run = 1000;
    logic p_ras = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_gnt && (!ras_n || !cas_n)) r5_viol = 1'b1;
            if (p_ras && !ras_n) begin
                falls++;
                check_eq("R6 cas lead", cas_pre, T_CSR);
                check_eq("R6 precharge gap ok", int'(hi_run >= T_RP), 1);
                hi_run = 0;
                cas_pre = 0;
            end
            if (!p_ras && ras_n) begin
                if (!sleep_mode) check_eq("R6 ras width", lo_run, T_RAS);
                check_eq("R6 cas rises with ras", int'(cas_n), 1);
                lo_run = 0;
            end
            if (!ras_n) lo_run++;
            else hi_run++;
            if (ras_n && !cas_n) cas_pre++;
            else if (cas_n) cas_pre = 0;
            p_ras = ras_n;
        end
    end

    task automatic wait_phase(input int p);
        do @(negedge clk); while ((cyc % INT) != p);
    endtask

    // R1: outputs during and right after reset.
    task automatic t_reset();
        repeat (5) @(negedge clk);
        check_eq("R1 ras_n", int'(ras_n), 1);
        check_eq("R1 cas_n", int'(cas_n), 1);
        check_eq("R1 bus_req", int'(bus_req), 0);
        check_eq("R1 sleep_ack", int'(sleep_ack), 0);
        rst_n = 1'b1;
    endtask

    // R3/R4/R5: three intervals without grant, then release.
    task automatic t_backlog();
        int f0;
        while (cyc != 3 * INT + 50) @(negedge clk);
        check_eq("R4 req while owed", int'(bus_req), 1);
        check_eq("R5 no strobes without grant", int'(r5_viol), 0);
        check_eq("R5 no falls without grant", falls, 0);
        f0 = falls;
        gate = 1'b1;
        wait_phase(95);
        check_eq("R3 backlog issued", falls - f0, 3);
        check_eq("R4 req dropped", int'(bus_req), 0);
    endtask

    // R3: six missed intervals saturate at PMAX.
    task automatic t_saturate();
        int f0;
        gate = 1'b0;
        f0 = falls;
        repeat (6) wait_phase(50);
        check_eq("R5 gated no falls", falls - f0, 0);
        gate = 1'b1;
        wait_phase(95);
        check_eq("R3 saturated count", falls - f0, PMAX);
        check_eq("R4 req dropped after burst", int'(bus_req), 0);
    endtask

    // R2: one refresh per interval in steady state.
    task automatic t_steady();
        int f0;
        wait_phase(50);
        f0 = falls;
        repeat (5) wait_phase(50);
        check_eq("R2 per-interval rate", falls - f0, 5);
        check_eq("R5 steady grant ok", int'(r5_viol), 0);
    endtask

    // R10/R7/R8/R9: sleep with refreshes owed, hold, wake, no burst.
    task automatic t_sleep();
        int f0, f1, n, guard;
        bit req_seen;
        wait_phase(50);
        gate = 1'b0;
        repeat (2) wait_phase(50);
        check_eq("R4 req with two owed", int'(bus_req), 1);
        sleep_mode = 1'b1;
        f0 = falls;
        sleep_req = 1'b1;
        gate = 1'b1;
        guard = 0;
        while (ras_n && guard < 50) begin @(negedge clk); guard++; end
        n = 0;
        while (!sleep_ack && n < 1000) begin @(negedge clk); n++; end
        check_eq("R7 ack after ras low", n, T_RASS);
        check_eq("R10 sleep first", falls - f0, 1);
        repeat (3 * INT) @(negedge clk);
        check_eq("R7 ras held low", int'(ras_n), 0);
        check_eq("R7 ack held", int'(sleep_ack), 1);
        check_eq("R9 no refresh in sleep", falls - f0, 1);
        sleep_req = 1'b0;
        @(negedge clk);
        check_eq("R8 ras up next clock", int'(ras_n), 1);
        check_eq("R8 cas up next clock", int'(cas_n), 1);
        n = 0;
        while (sleep_ack && n < 1000) begin @(negedge clk); n++; end
        check_eq("R8 ack after ras high", n, T_RPS);
        sleep_mode = 1'b0;
        f1 = falls;
        req_seen = 1'b0;
        repeat (INT - 1) begin
            @(negedge clk);
            if (bus_req) req_seen = 1'b1;
        end
        check_eq("R9 no request after wake", int'(req_seen), 0);
        check_eq("R9 no burst after wake", falls - f1, 0);
        repeat (20) @(negedge clk);
        check_eq("R9 refresh resumes", falls - f1, 1);
    endtask

    // Main sequence.
    initial begin
        t_reset();
        t_backlog();
        t_saturate();
        t_steady();
        t_sleep();
        check_eq("R5 overall", int'(r5_viol), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, errors);
            $finish;
        end
    end

endmodule